// File: doc/BRIEF.md
# Load/store pipeline with a shared register-file write slot

This block carries single-issue loads and stores between a register file and a small internal data cache. Each operation names a base register, a signed immediate and one more register: the destination for a load, the data source for a store. The base register is read through a dedicated read port in the issue cycle. The register file's write port is shared. A load uses it to write its result four cycles after issue. A store uses the same slot, at the same distance from issue, to read the value it will store. Because every operation claims exactly one slot, four cycles after it was accepted, the slot never has two claimants.

A load computes its address, checks it against the cache window, and then reads and aligns its word. Its result is written back in the following cycle. A store computes its address, checks the window, waits one stage, reads its data through the shared slot, and then merges the data into the addressed cache word. The cache word a load sees is read late, in its align stage. Two address comparators cover the only stores still in flight at that point: the one reading its data and the one merging. Their bytes are laid over the cached word, so every load observes all older stores in program order, and issue never stalls.

The cache holds 2^IDX_W words starting at address zero and always hits inside that window. Refills, multiple issue and arithmetic units are outside this block.

Top module: `ldst_slot_pipe`

## Requirements
- R1: While rst_n is low, in_ready, rf_we and rf_re are all low. After reset, every cache word reads as zero.
- R2: While rst_n is high, in_ready is high. One operation is accepted in every cycle that in_valid is high, back to back and without stalls.
- R3: The effective address is the base register value plus in_imm sign-extended from IMM_W bits, modulo 2^32.
- R4: A load accepted in cycle c drives rf_we high in cycle c+4, with rf_addr equal to its in_reg and rf_wdata equal to its result. In a cycle whose cycle-minus-four accepted nothing, both rf_we and rf_re are low.
- R5: A store accepted in cycle c drives rf_re high in cycle c+4, with rf_addr equal to its in_reg, and takes rf_rdata in that cycle as its data. rf_we and rf_re are never high in the same cycle.
- R6: in_size encodes 0 = byte, 1 = halfword, 2 = word, and accesses are naturally aligned. Bytes are little-endian: address bits [1:0] select the byte lane within a word. A load with in_signed = 1 sign-extends its result; with in_signed = 0 it zero-extends.
- R7: A store replaces only the bytes it addresses. The other bytes of the word keep their values.
- R8: A load returns the bytes of every older store to the same word, in program order, whatever the gap between them (including 0 to 3 idle cycles).
- R9: A store reads its data register after every older load has written it. A store accepted right after a load to its data register stores the loaded value.
- R10: An address with any bit above bit IDX_W+1 set lies outside the cache. A load there returns 0. A store there changes no cache word and is never forwarded to a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block accepts the offered operation |
| in_store | input | 1 | 1 = store, 0 = load |
| in_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| in_signed | input | 1 | Sign-extend load result |
| in_reg | input | RA_W | Load destination or store data register |
| in_base | input | RA_W | Base address register |
| in_imm | input | IMM_W | Signed address offset |
| rf_base_addr | output | RA_W | Register-file read port address (base) |
| rf_base_data | input | 32 | Register-file read port data |
| rf_we | output | 1 | Shared slot used as a write (load result) |
| rf_re | output | 1 | Shared slot used as a read (store data) |
| rf_addr | output | RA_W | Shared slot register number |
| rf_wdata | output | 32 | Load result written through the slot |
| rf_rdata | input | 32 | Store data read through the slot, same cycle |

## Verification
The assertions assume that rst_n is held low for at least one clock and that in_valid is low whenever rst_n is low. Under those conditions, every slot activity traces back to an acceptance four cycles earlier. The block also assumes that a base register is not the destination of a load issued in the four cycles before it is read, and that accesses are naturally aligned. The stimulus uses registers 1 to 6 only as bases, never loads into them, and generates only aligned addresses. The register file in the bench answers both read ports combinationally and writes on the clock edge.

// File: rtl/ldst_slot_pipe.sv
module ldst_slot_pipe #(
  parameter int IDX_W = 4,
  parameter int IMM_W = 12,
  parameter int RA_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_store,
  input  logic [1:0]       in_size,
  input  logic             in_signed,
  input  logic [RA_W-1:0]  in_reg,
  input  logic [RA_W-1:0]  in_base,
  input  logic [IMM_W-1:0] in_imm,
  output logic [RA_W-1:0]  rf_base_addr,
  input  logic [31:0]      rf_base_data,
  output logic             rf_we,
  output logic             rf_re,
  output logic [RA_W-1:0]  rf_addr,
  output logic [31:0]      rf_wdata,
  input  logic [31:0]      rf_rdata
);
  localparam int LINES = 1 << IDX_W;
  localparam int WA_W  = IDX_W + 2;

  function automatic logic [31:0] lane_merge(input logic [31:0] w, input logic [31:0] d,
                                             input logic [1:0] sz, input logic [1:0] off);
    logic [31:0] m;
    m = (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
    m = m << {off, 3'b000};
    return (w & ~m) | ((d << {off, 3'b000}) & m);
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] w, input logic [1:0] sz,
                                            input logic [1:0] off, input logic sg);
    logic [31:0] s;
    s = w >> {off, 3'b000};
    case (sz)
      2'd0:    return {{24{sg & s[7]}}, s[7:0]};
      2'd1:    return {{16{sg & s[15]}}, s[15:0]};
      default: return s;
    endcase
  endfunction

  logic [31:0] mem [LINES];

  logic             s1_v, s1_st, s1_sg;
  logic [1:0]       s1_sz;
  logic [RA_W-1:0]  s1_r;
  logic [31:0]      s1_base;
  logic [IMM_W-1:0] s1_imm;

  logic            s2_v, s2_st, s2_sg;
  logic [1:0]      s2_sz;
  logic [RA_W-1:0] s2_r;
  logic [31:0]     s2_a;

  logic            s3_v, s3_st, s3_sg, s3_hit;
  logic [1:0]      s3_sz;
  logic [RA_W-1:0] s3_r;
  logic [WA_W-1:0] s3_wa;

  logic            s4_v, s4_st, s4_hit;
  logic [1:0]      s4_sz;
  logic [RA_W-1:0] s4_r;
  logic [WA_W-1:0] s4_wa;
  logic [31:0]     s4_data;

  logic            s5_v;
  logic [1:0]      s5_sz;
  logic [WA_W-1:0] s5_wa;
  logic [31:0]     s5_data;

  logic [31:0] s5_word, f_base, f_word, ld_val;
  logic        fwd_old, fwd_new;

  assign in_ready     = rst_n;
  assign rf_base_addr = in_base;
  assign rf_we        = s4_v & ~s4_st;
  assign rf_re        = s4_v & s4_st;
  assign rf_addr      = s4_r;
  assign rf_wdata     = s4_data;

  assign s5_word = lane_merge(mem[s5_wa[WA_W-1:2]], s5_data, s5_sz, s5_wa[1:0]);
  assign fwd_old = s5_v && s5_wa[WA_W-1:2] == s3_wa[WA_W-1:2];
  assign fwd_new = s4_v && s4_st && s4_hit && s4_wa[WA_W-1:2] == s3_wa[WA_W-1:2];
  assign f_base  = fwd_old ? s5_word : mem[s3_wa[WA_W-1:2]];
  assign f_word  = fwd_new ? lane_merge(f_base, rf_rdata, s4_sz, s4_wa[1:0]) : f_base;
  assign ld_val  = s3_hit ? lane_pick(f_word, s3_sz, s3_wa[1:0], s3_sg) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0; s4_v <= 1'b0; s5_v <= 1'b0;
      s1_st <= 1'b0; s1_sg <= 1'b0; s1_sz <= '0; s1_r <= '0; s1_base <= '0; s1_imm <= '0;
      s2_st <= 1'b0; s2_sg <= 1'b0; s2_sz <= '0; s2_r <= '0; s2_a <= '0;
      s3_st <= 1'b0; s3_sg <= 1'b0; s3_hit <= 1'b0; s3_sz <= '0; s3_r <= '0; s3_wa <= '0;
      s4_st <= 1'b0; s4_hit <= 1'b0; s4_sz <= '0; s4_r <= '0; s4_wa <= '0; s4_data <= '0;
      s5_sz <= '0; s5_wa <= '0; s5_data <= '0;
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else begin
      s1_v    <= in_valid & in_ready;
      s1_st   <= in_store;
      s1_sg   <= in_signed;
      s1_sz   <= in_size;
      s1_r    <= in_reg;
      s1_base <= rf_base_data;
      s1_imm  <= in_imm;

      s2_v  <= s1_v;
      s2_st <= s1_st;
      s2_sg <= s1_sg;
      s2_sz <= s1_sz;
      s2_r  <= s1_r;
      s2_a  <= s1_base + {{(32-IMM_W){s1_imm[IMM_W-1]}}, s1_imm};

      s3_v   <= s2_v;
      s3_st  <= s2_st;
      s3_sg  <= s2_sg;
      s3_sz  <= s2_sz;
      s3_r   <= s2_r;
      s3_wa  <= s2_a[WA_W-1:0];
      s3_hit <= s2_a[31:WA_W] == '0;

      s4_v    <= s3_v;
      s4_st   <= s3_st;
      s4_sz   <= s3_sz;
      s4_r    <= s3_r;
      s4_wa   <= s3_wa;
      s4_hit  <= s3_hit;
      s4_data <= ld_val;

      s5_v    <= s4_v & s4_st & s4_hit;
      s5_sz   <= s4_sz;
      s5_wa   <= s4_wa;
      s5_data <= rf_rdata;

      if (s5_v) mem[s5_wa[WA_W-1:2]] <= s5_word;
    end
  end
endmodule

module ldst_slot_pipe_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic in_store,
  input logic rf_we,
  input logic rf_re
);
  p_slot_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re));

  p_load_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_store) |-> ##4 (rf_we && !rf_re));

  p_store_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_store) |-> ##4 (rf_re && !rf_we));

  p_no_stray_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we || rf_re) |-> $past(in_valid && in_ready, 4));
endmodule

bind ldst_slot_pipe ldst_slot_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_store(in_store), .rf_we(rf_we), .rf_re(rf_re)
);

// File: tb/ldst_slot_pipe_test.sv
`timescale 1ns/1ps
module ldst_slot_pipe_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, in_store, in_signed;
  logic [1:0] in_size;
  logic [4:0] in_reg, in_base, rf_base_addr, rf_addr;
  logic [11:0] in_imm;
  logic [31:0] rf_base_data, rf_wdata, rf_rdata;
  logic rf_we, rf_re;

  ldst_slot_pipe uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_store(in_store), .in_size(in_size), .in_signed(in_signed),
    .in_reg(in_reg), .in_base(in_base), .in_imm(in_imm),
    .rf_base_addr(rf_base_addr), .rf_base_data(rf_base_data),
    .rf_we(rf_we), .rf_re(rf_re), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  function automatic logic [31:0] rinit(input int i);
    case (i)
      1: return 32'd0;
      2: return 32'd16;
      3: return 32'd48;
      4: return 32'd64;
      5: return 32'hFFFF_FFF0;
      6: return 32'd60;
      default: return (32'h9E37_79B9 * (i + 1)) ^ (i << 9);
    endcase
  endfunction

  logic [31:0] rf [32];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= rinit(i);
    end else if (rf_we) rf[rf_addr] <= rf_wdata;
  end
  assign rf_base_data = rf[rf_base_addr];
  assign rf_rdata     = rf[rf_addr];

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errs = 0, checks = 0;
  logic [31:0] mreg [32];
  logic [7:0]  mb [64];
  int          sk [16];
  logic [4:0]  sr [16];
  logic [31:0] sd [16];
  string       stag [16];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    int i;
    @(negedge clk);
    i = cyc % 16;
    case (sk[i])
      0: chk(!rf_we && !rf_re, "R4 slot idle without issue", {30'd0, rf_we, rf_re}, 32'd0);
      1: chk(rf_we && !rf_re && rf_addr == sr[i] && rf_wdata == sd[i],
             {"R4 load writeback / ", stag[i]}, rf_wdata, sd[i]);
      default: chk(rf_re && !rf_we && rf_addr == sr[i],
                   {"R5 store data read / ", stag[i]}, {27'd0, rf_addr}, {27'd0, sr[i]});
    endcase
    sk[i] = 0;
  endtask

  task automatic idle();
    tick();
    in_valid = 1'b0;
  endtask

  task automatic op(input bit st, input logic [1:0] sz, input bit sg, input int r,
                    input int b, input int imm, input string tag);
    logic [31:0] a, v;
    int s;
    tick();
    chk(in_ready, "R2 ready while running", {31'd0, in_ready}, 32'd1);
    in_valid = 1'b1; in_store = st; in_size = sz; in_signed = sg;
    in_reg = r[4:0]; in_base = b[4:0]; in_imm = imm[11:0];
    a = mreg[b] + 32'(imm);
    s = (cyc + 4) % 16;
    sr[s] = r[4:0];
    stag[s] = tag;
    if (st) begin
      sk[s] = 2;
      if (a < 32'd64) begin
        mb[a] = mreg[r][7:0];
        if (sz != 2'd0) mb[a + 1] = mreg[r][15:8];
        if (sz == 2'd2) begin
          mb[a + 2] = mreg[r][23:16];
          mb[a + 3] = mreg[r][31:24];
        end
      end
    end else begin
      sk[s] = 1;
      v = 32'd0;
      if (a < 32'd64) begin
        case (sz)
          2'd0: v = sg ? {{24{mb[a][7]}}, mb[a]} : {24'd0, mb[a]};
          2'd1: v = sg ? {{16{mb[a + 1][7]}}, mb[a + 1], mb[a]} : {16'd0, mb[a + 1], mb[a]};
          default: v = {mb[a + 3], mb[a + 2], mb[a + 1], mb[a]};
        endcase
      end
      sd[s] = v;
      mreg[r] = v;
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_store = 1'b0; in_size = 2'd0; in_signed = 1'b0;
    in_reg = '0; in_base = '0; in_imm = '0;
    for (int i = 0; i < 16; i++) sk[i] = 0;
    for (int i = 0; i < 32; i++) mreg[i] = rinit(i);
    for (int i = 0; i < 64; i++) mb[i] = 8'd0;
    repeat (4) begin
      @(negedge clk);
      chk(!in_ready && !rf_we && !rf_re, "R1 quiet during reset",
          {29'd0, in_ready, rf_we, rf_re}, 32'd0);
    end
    rst_n = 1'b1;

    for (int a = 0; a < 64; a += 4) op(0, 2, 0, 31, 1, a, "R1 cache zero after reset");

    for (int a = 0; a < 64; a++) op(1, 0, 0, 8 + a % 23, 1, a, "R7 byte store sweep");
    for (int a = 0; a < 64; a++) op(0, 0, 1, 24 + a % 7, 1, a, "R6 signed byte");
    for (int a = 0; a < 64; a++) op(0, 0, 0, 24 + a % 7, 1, a, "R6 unsigned byte");
    for (int a = 0; a < 64; a += 2) op(0, 1, 1, 9 + a % 5, 1, a, "R6 signed half");
    for (int a = 0; a < 64; a += 2) op(0, 1, 0, 9 + a % 5, 1, a, "R6 unsigned half");
    for (int a = 0; a < 64; a += 2) op(1, 1, 0, 14 + a % 9, 1, a, "R7 half store sweep");
    for (int a = 0; a < 64; a += 4) op(0, 2, 0, 31, 1, a, "R7 words after half stores");
    for (int a = 0; a < 64; a += 8) op(1, 2, 0, 8 + a / 8, 1, a, "R7 word store");
    for (int a = 0; a < 64; a++) op(0, 0, 1, 30, 1, a, "R7 bytes after word stores");

    for (int g = 0; g < 6; g++) begin
      op(1, 2, 0, 10 + g, 1, 20, "R8 word store");
      repeat (g) idle();
      op(0, 2, 0, 31, 1, 20, "R8 forwarded word");
      op(1, 0, 0, 17 + g, 1, 21 + g % 3, "R8 byte store");
      repeat (g) idle();
      op(0, 1, 1, 29, 1, 20 + 2 * (g % 2), "R8 forwarded half");
    end
    op(1, 0, 0, 12, 1, 36, "R8 first byte");
    op(1, 1, 0, 13, 1, 38, "R8 second half");
    op(1, 0, 0, 14, 1, 37, "R8 third byte");
    op(0, 2, 0, 31, 1, 36, "R8 three stores combined");

    for (int k = -48; k <= 12; k += 4) op(0, 2, 0, 28, 3, k, "R3 negative offset");
    for (int k = 16; k < 80; k += 4) op(0, 2, 0, 27, 5, k, "R3 wrap-around add");
    op(1, 2, 0, 11, 6, -60, "R3 store via negative offset");
    op(0, 2, 0, 26, 2, -16, "R3 read back at zero");

    op(1, 2, 0, 15, 4, 20, "R10 store above window");
    op(0, 2, 0, 31, 1, 20, "R10 alias word unchanged");
    op(0, 2, 0, 25, 4, 4, "R10 load above window is zero");
    op(1, 1, 0, 16, 1, -4, "R10 store at negative address");
    op(0, 2, 0, 25, 1, 60, "R10 top word unchanged");
    op(0, 1, 1, 25, 1, -4, "R10 load at negative address is zero");

    op(0, 2, 0, 9, 1, 8, "R9 load into data register");
    op(1, 2, 0, 9, 1, 40, "R9 store right after load");
    op(0, 2, 0, 31, 1, 40, "R9 stored value is the loaded one");
    op(0, 0, 0, 20, 1, 33, "R9 byte load into data register");
    op(1, 0, 0, 20, 1, 44, "R9 byte store right after load");
    idle();
    op(0, 2, 0, 31, 1, 44, "R9 byte merged");

    repeat (8) idle();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule